// File: doc/BRIEF.md
# Zero-Aware Cache Writeback Filter

The filter sits between an inner write-back cache level and the next level out. It keeps a small array of 64-byte lines, each with a coherence-style state (invalid, shared, exclusive, modified) and two extra bits: whether the line's data was entirely zero when it was installed, and whether the install came from beyond the outer level rather than from a hit in it. Lines are installed through a fill port and written through a byte-masked store port. When the inner level evicts a line, the filter decides what, if anything, goes outward.

An eviction is taken in on a valid/ready request. The cycle after acceptance, a registered OR-reduction of the full line's data is available, and the filter picks one of four outcomes: dropped silently, eliminated (a modified line whose content is all zero and whose fill content was all zero too), written back with data, or sent as a data-less notification. Only the last two use the outbound valid/ready port. Back-pressure rules: a new eviction is accepted only while the filter is idle; while an outbound message is waiting, its data, kind and index stay fixed and no eviction is accepted until the outer level takes it. Three saturating counters tally silent, non-silent and eliminated outcomes.

Top module: `zwb_filter`

## Requirements
- R1: A line filled on an outer-level hit (far flag 0) and never stored to is evicted silently: outcome code 0, no outbound message.
- R2: A line filled from beyond the outer level (far flag 1) and never stored to produces an outbound notification with wb_note 1 and wb_data all zero; outcome code 3.
- R3: A modified line whose fill data was entirely zero and whose content at eviction is entirely zero is eliminated: outcome code 1, no outbound message, and ev_ack is high in the cycle right after the request is accepted. The far flag does not change this.
- R4: A modified line that fails the zero test is sent out with wb_note 0 and wb_data equal to the fill data with each stored byte replaced (byte b is bits 8b+7..8b, enabled by st_be[b]); outcome code 2.
- R5: Only the content at eviction matters: bytes set non-zero and later stored back to zero, and bytes never stored, do not prevent elimination.
- R6: A line whose fill data had any non-zero byte is written back with data even if its content has been stored to all zero.
- R7: ev_req_ready is high only while idle and falls for at least one cycle after each acceptance; while wb_valid is high and wb_ready low, wb_valid, wb_data and wb_note hold; ev_ack rises in the cycle wb_valid and wb_ready are both high.
- R8: cnt_silent counts outcome 0, cnt_nonsilent outcomes 2 and 3, cnt_elim outcome 1; each increments at the clock edge ending the ev_ack cycle and holds at its maximum.
- R9: A store to an invalid line has no effect; evicting an invalid line gives outcome 0 with no outbound message.
- R10: After synchronous reset all lines are invalid, ev_req_ready is 1, wb_valid and ev_ack are 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Install a line this cycle |
| fill_idx | input | IDX_W | Line slot to install |
| fill_data | input | LINE_BYTES*8 | Fill contents |
| fill_excl | input | 1 | 1 installs exclusive, 0 shared |
| fill_far | input | 1 | 1 when the fill came from beyond the outer level |
| st_valid | input | 1 | Store this cycle |
| st_idx | input | IDX_W | Line slot stored to |
| st_data | input | LINE_BYTES*8 | Store data, byte-aligned to the line |
| st_be | input | LINE_BYTES | Byte enables |
| ev_req_valid | input | 1 | Eviction request |
| ev_req_ready | output | 1 | Filter idle and accepting an eviction |
| ev_idx | input | IDX_W | Line slot to evict |
| ev_ack | output | 1 | Eviction finished this cycle |
| ev_outcome | output | 2 | 0 silent, 1 eliminated, 2 data, 3 notification |
| wb_valid | output | 1 | Outbound message valid |
| wb_ready | input | 1 | Outer level takes the message |
| wb_note | output | 1 | 1 notification, 0 data writeback |
| wb_idx | output | IDX_W | Slot of the outbound line |
| wb_data | output | LINE_BYTES*8 | Outbound line data |
| cnt_silent | output | CNT_W | Silent eviction count |
| cnt_nonsilent | output | CNT_W | Non-silent eviction count |
| cnt_elim | output | CNT_W | Eliminated writeback count |

## Verification
Lines are driven through zero fills with no stores, with zero-valued partial stores, with non-zero stores later cleared, and with stores that stay non-zero, which separates elimination from a data writeback on the strength of the eviction-time content alone. Non-zero fills later cleared to zero tell the fill-time flag apart from the eviction-time test. Near and far unmodified fills separate silent drops from notifications, stalled outbound ready checks the hold and blocking rules, and a long run of silent evictions with narrow counters reaches saturation.

// File: rtl/zwb_pkg.sv
package zwb_pkg;
  typedef enum logic [1:0] {ST_INV = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2, ST_MOD = 2'd3} line_state_e;
  typedef enum logic [1:0] {EV_SILENT = 2'd0, EV_ELIM = 2'd1, EV_DATA = 2'd2, EV_NOTE = 2'd3} ev_outcome_e;
  typedef struct packed {
    line_state_e st;
    logic        zero_at_fill;
    logic        from_far;
  } line_meta_t;
endpackage

// File: rtl/zwb_line_store.sv
module zwb_line_store
  import zwb_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 64,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_valid,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic [LINE_BITS-1:0]  fill_data,
  input  logic                  fill_excl,
  input  logic                  fill_far,
  input  logic                  st_valid,
  input  logic [IDX_W-1:0]      st_idx,
  input  logic [LINE_BITS-1:0]  st_data,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic                  inv_valid,
  input  logic [IDX_W-1:0]      inv_idx,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [LINE_BITS-1:0]  rd_data,
  output line_meta_t            rd_meta
);
  logic [LINE_BITS-1:0] data_vec [NUM_LINES];
  line_meta_t           meta_vec [NUM_LINES];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [LINE_BITS-1:0] data_q;
    line_meta_t           meta_q;
    logic                 hit_fill, hit_inv, hit_st;

    assign hit_fill = fill_valid && (fill_idx == IDX_W'(l));
    assign hit_inv  = inv_valid && (inv_idx == IDX_W'(l));
    assign hit_st   = st_valid && (st_idx == IDX_W'(l)) && (meta_q.st != ST_INV) && !hit_fill;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= '{st: ST_INV, zero_at_fill: 1'b0, from_far: 1'b0};
        data_q <= '0;
      end else begin
        if (hit_fill) begin
          meta_q.st           <= fill_excl ? ST_EXC : ST_SHR;
          meta_q.zero_at_fill <= ~|fill_data;
          meta_q.from_far     <= fill_far;
          data_q              <= fill_data;
        end else if (hit_inv) begin
          meta_q.st <= ST_INV;
        end else if (hit_st) begin
          meta_q.st <= ST_MOD;
          for (int b = 0; b < LINE_BYTES; b++) begin
            if (st_be[b]) data_q[8*b +: 8] <= st_data[8*b +: 8];
          end
        end
      end
    end

    assign data_vec[l] = data_q;
    assign meta_vec[l] = meta_q;
  end

  assign rd_data = data_vec[rd_idx];
  assign rd_meta = meta_vec[rd_idx];
endmodule

// File: rtl/zwb_zero_detect.sv
module zwb_zero_detect #(
  parameter int LINE_BITS = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [LINE_BITS-1:0] line_in,
  output logic                 is_zero_q,
  output logic [LINE_BITS-1:0] snap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_zero_q <= 1'b0;
      snap_q    <= '0;
    end else if (load) begin
      is_zero_q <= ~|line_in;
      snap_q    <= line_in;
    end
  end
endmodule

// File: rtl/zwb_sat_cnt.sv
module zwb_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (inc && !(&count)) count <= count + 1'b1;
  end
endmodule

// File: rtl/zwb_filter.sv
module zwb_filter
  import zwb_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 16,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_valid,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic [LINE_BITS-1:0]  fill_data,
  input  logic                  fill_excl,
  input  logic                  fill_far,
  input  logic                  st_valid,
  input  logic [IDX_W-1:0]      st_idx,
  input  logic [LINE_BITS-1:0]  st_data,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic                  ev_req_valid,
  output logic                  ev_req_ready,
  input  logic [IDX_W-1:0]      ev_idx,
  output logic                  ev_ack,
  output logic [1:0]            ev_outcome,
  output logic                  wb_valid,
  input  logic                  wb_ready,
  output logic                  wb_note,
  output logic [IDX_W-1:0]      wb_idx,
  output logic [LINE_BITS-1:0]  wb_data,
  output logic [CNT_W-1:0]      cnt_silent,
  output logic [CNT_W-1:0]      cnt_nonsilent,
  output logic [CNT_W-1:0]      cnt_elim
);
  logic                 busy_q;
  logic [IDX_W-1:0]     idx_q;
  line_meta_t           meta_q;
  line_meta_t           rd_meta;
  logic [LINE_BITS-1:0] rd_data, snap_q;
  logic                 is_zero_q;
  logic                 accept, needs_wb, done;
  ev_outcome_e          outcome;
  logic [2:0]           cnt_inc;
  logic [CNT_W-1:0]     cnt_vals [3];

  assign accept       = ev_req_valid && !busy_q;
  assign ev_req_ready = !busy_q;

  zwb_line_store #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
    .fill_excl(fill_excl), .fill_far(fill_far),
    .st_valid(st_valid), .st_idx(st_idx), .st_data(st_data), .st_be(st_be),
    .inv_valid(done), .inv_idx(idx_q),
    .rd_idx(ev_idx), .rd_data(rd_data), .rd_meta(rd_meta)
  );

  zwb_zero_detect #(.LINE_BITS(LINE_BITS)) u_zero (
    .clk(clk), .rst_n(rst_n), .load(accept), .line_in(rd_data),
    .is_zero_q(is_zero_q), .snap_q(snap_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      meta_q <= '{st: ST_INV, zero_at_fill: 1'b0, from_far: 1'b0};
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= ev_idx;
      meta_q <= rd_meta;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (meta_q.st)
      ST_MOD:         outcome = (is_zero_q && meta_q.zero_at_fill) ? EV_ELIM : EV_DATA;
      ST_SHR, ST_EXC: outcome = meta_q.from_far ? EV_NOTE : EV_SILENT;
      default:        outcome = EV_SILENT;
    endcase
  end

  assign needs_wb   = (outcome == EV_DATA) || (outcome == EV_NOTE);
  assign wb_valid   = busy_q && needs_wb;
  assign wb_note    = (outcome == EV_NOTE);
  assign wb_idx     = idx_q;
  assign wb_data    = (outcome == EV_DATA) ? snap_q : '0;
  assign done       = busy_q && (!needs_wb || wb_ready);
  assign ev_ack     = done;
  assign ev_outcome = outcome;

  assign cnt_inc[0] = done && (outcome == EV_SILENT);
  assign cnt_inc[1] = done && needs_wb;
  assign cnt_inc[2] = done && (outcome == EV_ELIM);

  for (genvar c = 0; c < 3; c++) begin : g_cnt
    zwb_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[c]), .count(cnt_vals[c])
    );
  end

  assign cnt_silent    = cnt_vals[0];
  assign cnt_nonsilent = cnt_vals[1];
  assign cnt_elim      = cnt_vals[2];
endmodule

// File: rtl/zwb_filter_chk.sv
module zwb_filter_chk #(
  parameter int CNT_W     = 16,
  parameter int LINE_BITS = 512
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ev_req_valid,
  input logic                 ev_req_ready,
  input logic                 ev_ack,
  input logic [1:0]           ev_outcome,
  input logic                 wb_valid,
  input logic                 wb_ready,
  input logic                 wb_note,
  input logic [LINE_BITS-1:0] wb_data,
  input logic [CNT_W-1:0]     cnt_silent,
  input logic [CNT_W-1:0]     cnt_nonsilent,
  input logic [CNT_W-1:0]     cnt_elim
);
  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_note));

  a_r7_block_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !ev_req_ready);

  a_r7_accept_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req_valid && ev_req_ready |=> !ev_req_ready);

  a_r3_elim_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack && ev_outcome == 2'd1 |-> !wb_valid);

  a_r2_note_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_note |-> wb_data == '0);

  a_r8_elim_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, cnt_elim} == {1'b0, $past(cnt_elim)}) || ({1'b0, cnt_elim} == {1'b0, $past(cnt_elim)} + 1'b1));

  a_r8_silent_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, cnt_silent} == {1'b0, $past(cnt_silent)}) || ({1'b0, cnt_silent} == {1'b0, $past(cnt_silent)} + 1'b1));

  a_r8_nonsilent_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, cnt_nonsilent} == {1'b0, $past(cnt_nonsilent)}) || ({1'b0, cnt_nonsilent} == {1'b0, $past(cnt_nonsilent)} + 1'b1));
endmodule

bind zwb_filter zwb_filter_chk #(.CNT_W(CNT_W), .LINE_BITS(LINE_BITS)) u_chk (.*);

// File: tb/tb_zwb_filter.sv
module tb_zwb_filter;
  localparam int NL = 4;
  localparam int LB = 64;
  localparam int LW = LB * 8;
  localparam int IW = 2;
  localparam int CW = 3;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 0, fill_excl = 0, fill_far = 0;
  logic [IW-1:0] fill_idx = '0;
  logic [LW-1:0] fill_data = '0;
  logic st_valid = 0;
  logic [IW-1:0] st_idx = '0;
  logic [LW-1:0] st_data = '0;
  logic [LB-1:0] st_be = '0;
  logic ev_req_valid = 0;
  logic ev_req_ready;
  logic [IW-1:0] ev_idx = '0;
  logic ev_ack;
  logic [1:0] ev_outcome;
  logic wb_valid, wb_note;
  logic wb_ready = 1'b1;
  logic [IW-1:0] wb_idx;
  logic [LW-1:0] wb_data;
  logic [CW-1:0] cnt_silent, cnt_nonsilent, cnt_elim;

  always #4 clk = ~clk;

  zwb_filter #(.NUM_LINES(NL), .LINE_BYTES(LB), .CNT_W(CW)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [LW-1:0] m_data [NL];
  int  m_st [NL];
  bit  m_zf [NL];
  bit  m_far [NL];
  int  m_sil = 0, m_non = 0, m_elim = 0;
  bit  m_busy = 0;
  bit  in_reset = 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_out(input int i);
    if (m_st[i] == 3) return (m_data[i] == '0 && m_zf[i]) ? 1 : 2;
    if (m_st[i] == 1 || m_st[i] == 2) return m_far[i] ? 3 : 0;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (!in_reset && !finished) begin
      chk(cnt_silent == CW'(m_sil), "R8 silent count", 64'(cnt_silent), 64'(m_sil));
      chk(cnt_nonsilent == CW'(m_non), "R8 nonsilent count", 64'(cnt_nonsilent), 64'(m_non));
      chk(cnt_elim == CW'(m_elim), "R8 elim count", 64'(cnt_elim), 64'(m_elim));
      if (!m_busy) begin
        chk(ev_req_ready == 1'b1, "R7 idle ready", 64'(ev_req_ready), 64'd1);
        chk(wb_valid == 1'b0, "R7 idle no wb", 64'(wb_valid), 64'd0);
        chk(ev_ack == 1'b0, "R7 idle no ack", 64'(ev_ack), 64'd0);
      end
    end
  end

  task automatic do_fill(input int i, input logic [LW-1:0] d, input bit excl, input bit far);
    @(negedge clk);
    fill_valid = 1; fill_idx = IW'(i); fill_data = d; fill_excl = excl; fill_far = far;
    @(posedge clk);
    m_data[i] = d; m_st[i] = excl ? 2 : 1; m_zf[i] = (d == '0); m_far[i] = far;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_store(input int i, input logic [LW-1:0] d, input logic [LB-1:0] be);
    @(negedge clk);
    st_valid = 1; st_idx = IW'(i); st_data = d; st_be = be;
    @(posedge clk);
    if (m_st[i] != 0) begin
      for (int b = 0; b < LB; b++) if (be[b]) m_data[i][8*b +: 8] = d[8*b +: 8];
      m_st[i] = 3;
    end
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic do_evict(input int i, input int stall, input string tag);
    int eo;
    logic [LW-1:0] ed;
    eo = exp_out(i);
    ed = (eo == 2) ? m_data[i] : '0;
    @(negedge clk);
    ev_req_valid = 1; ev_idx = IW'(i);
    if (stall > 0) wb_ready = 0;
    @(posedge clk);
    m_busy = 1;
    @(negedge clk);
    ev_req_valid = 0;
    chk(ev_outcome == 2'(eo), {tag, " outcome"}, 64'(ev_outcome), 64'(eo));
    if (eo >= 2) begin
      chk(wb_valid == 1'b1, {tag, " wb_valid"}, 64'(wb_valid), 64'd1);
      chk(wb_note == (eo == 3), {tag, " wb_note"}, 64'(wb_note), 64'(eo == 3));
      chk(wb_data == ed, {tag, " wb_data"}, wb_data[63:0], ed[63:0]);
      chk(wb_idx == IW'(i), {tag, " wb_idx"}, 64'(wb_idx), 64'(i));
      for (int k = 0; k < stall; k++) begin
        chk(ev_ack == 1'b0 && ev_req_ready == 1'b0, "R7 stalled no ack no ready", 64'({ev_ack, ev_req_ready}), 64'd0);
        chk(wb_valid == 1'b1 && wb_data == ed, "R7 stalled hold", wb_data[63:0], ed[63:0]);
        @(negedge clk);
      end
      wb_ready = 1;
      #1;
      chk(ev_ack == 1'b1, "R7 ack on handshake", 64'(ev_ack), 64'd1);
    end else begin
      chk(ev_ack == 1'b1, {tag, " ack next cycle"}, 64'(ev_ack), 64'd1);
      chk(wb_valid == 1'b0, {tag, " no outbound"}, 64'(wb_valid), 64'd0);
    end
    @(posedge clk);
    if (eo == 0) m_sil = (m_sil < CMAX) ? m_sil + 1 : m_sil;
    else if (eo == 1) m_elim = (m_elim < CMAX) ? m_elim + 1 : m_elim;
    else m_non = (m_non < CMAX) ? m_non + 1 : m_non;
    m_st[i] = 0;
    m_busy = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] pat, zero_d, one_d;
    for (int i = 0; i < NL; i++) begin m_data[i] = '0; m_st[i] = 0; m_zf[i] = 0; m_far[i] = 0; end
    pat = '0;
    for (int b = 0; b < LB; b++) pat[8*b +: 8] = 8'(b * 7 + 3);
    zero_d = '0;
    one_d = '0;
    for (int b = 0; b < LB; b++) one_d[8*b +: 8] = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    in_reset = 0;
    #1;
    // R10 reset state
    chk(ev_req_ready == 1 && wb_valid == 0 && ev_ack == 0, "R10 reset handshake", 64'({ev_req_ready, wb_valid, ev_ack}), 64'b100);
    chk(cnt_silent == 0 && cnt_nonsilent == 0 && cnt_elim == 0, "R10 reset counters", 64'({cnt_silent, cnt_nonsilent, cnt_elim}), 64'd0);

    // R1 near fill, no store
    do_fill(0, pat, 1'b0, 1'b0);
    do_evict(0, 0, "R1 near shared");
    do_fill(1, pat, 1'b1, 1'b0);
    do_evict(1, 0, "R1 near exclusive");

    // R2 far fill, no store
    do_fill(2, pat, 1'b1, 1'b1);
    do_evict(2, 0, "R2 far notify");

    // R3 zero fill, partial zero stores
    do_fill(0, zero_d, 1'b1, 1'b0);
    do_store(0, zero_d, 64'h0000_0000_0000_00F0);
    do_evict(0, 0, "R3 zero over zero");
    do_fill(3, zero_d, 1'b1, 1'b1);
    do_store(3, zero_d, 64'h1);
    do_evict(3, 0, "R3 far zero over zero");

    // R5 non-zero then cleared
    do_fill(1, zero_d, 1'b1, 1'b0);
    do_store(1, one_d, 64'hFF00);
    do_store(1, zero_d, 64'hFF00);
    do_evict(1, 0, "R5 cleared before evict");

    // R4 non-zero remains, with byte mask and back-pressure
    do_fill(2, zero_d, 1'b0, 1'b0);
    do_store(2, pat, 64'h8000_0000_0000_0001);
    do_evict(2, 3, "R4 data stalled");
    do_fill(0, pat, 1'b1, 1'b0);
    do_store(0, one_d, 64'h0F0F_0000_0000_F000);
    do_evict(0, 0, "R4 merged data");

    // R6 non-zero fill cleared to zero
    do_fill(1, pat, 1'b1, 1'b0);
    do_store(1, zero_d, '1);
    do_evict(1, 1, "R6 nonzero fill");

    // R9 store to invalid line, evict invalid
    do_store(1, one_d, '1);
    do_evict(1, 0, "R9 invalid line");

    // R8 saturation
    for (int k = 0; k < 8; k++) begin
      do_fill(3, pat, 1'b0, 1'b0);
      do_evict(3, 0, "R8 silent run");
    end
    @(negedge clk);
    chk(cnt_silent == CW'(CMAX), "R8 saturated silent", 64'(cnt_silent), 64'(CMAX));

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule